// File: doc/BRIEF.md
# Single-Wire Sensor Reply Emulator

This block models the sensor end of a single-wire, open-drain link for temperature and humidity readings. It watches the shared line for a long low pulse from the host. Once the host lets the line go high again, the block waits a short gap. It then pulls the line low and releases it to form a fixed two-phase reply preamble. After that it sends a parallel data word one bit at a time. Every bit opens with a fixed low slot. The length of the high phase that follows carries the bit value. A final low slot closes the last bit.

The block only ever asserts a pull-low enable. A pad cell and an external pull-up outside the block form the wired line, and the line level comes back in on `bus_in`. Every duration is a cycle count. Each count equals the duration in nanoseconds divided by the clock period generic `CLK_NS`, plus one. The reset `rst_n` is asynchronous and active low, and it is expected to be released in step with the clock.

Top module: `dwire_sensor_tx`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after its release, `pull_low`, `busy` and `done` are all 0.
- R2: A transaction starts only when the line has stayed low for at least C_START = 500000/CLK_NS+1 consecutive cycles before the host releases it; a shorter low pulse leaves `busy` and `pull_low` at 0.
- R3: `pull_low` first rises exactly C_WAIT+3 clock edges after the first edge that samples the released line, where C_WAIT = 40000/CLK_NS+1 (two cycles of synchronizer and one of edge detection precede the gap).
- R4: The reply preamble holds `pull_low` at 1 for C_PRE = 80000/CLK_NS+1 cycles and then at 0 for C_PRE cycles.
- R5: Every data bit begins with `pull_low` at 1 for C_SLOT = 50000/CLK_NS+1 cycles.
- R6: After its low slot, a 0 bit keeps `pull_low` at 0 for C_ZERO = 24000/CLK_NS+1 cycles, and a 1 bit keeps it at 0 for C_ONE = 68000/CLK_NS+1 cycles.
- R7: The WORD_W bits of the word are sent with the most significant bit first.
- R8: After the high phase of the last bit, `pull_low` is 1 for C_SLOT cycles and then returns to 0.
- R9: The word on `word_in` is captured on the cycle the start is accepted, and later changes to `word_in` have no effect on the bits being sent.
- R10: `busy` is 1 from the accepted start until the trailing low slot ends. `pull_low` is 1 only while `busy` is 1. `done` is a single-cycle pulse on the cycle `busy` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock with period CLK_NS nanoseconds |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 1 | Level of the shared line (asynchronous) |
| word_in | input | WORD_W | Data word to send, captured at start |
| pull_low | output | 1 | Enable for the open-drain pull-down of the line |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse when the line is finally released |

## Verification
Host low pulses of C_START-1 and exactly C_START cycles test whether the start threshold sits on the right cycle. Words of all zeros, all ones and alternating bits confirm that each high-phase length follows its own bit and not a neighbour. A single set bit at the MSB shows whether the bit order is reversed. Random words, with `word_in` rewritten in the middle of each frame, show whether the capture is a true snapshot or reads the live input. Every low and high run is measured in whole cycles, so any off-by-one in a count reload changes at least one measured width.

// File: rtl/dws_pkg.sv
package dws_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_PRE_LO,
    ST_PRE_HI,
    ST_BIT_LO,
    ST_BIT_HI,
    ST_TAIL_LO
  } dws_state_e;

  // duration in ns converted to a cycle count for a given clock period
  function automatic int dur_cycles(input int ns, input int clk_ns);
    return ns / clk_ns + 1;
  endfunction

endpackage

// File: rtl/dws_sync.sv
module dws_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic rise
);
  // sh[STAGES-1:0] synchronizer, sh[STAGES] previous synchronized level
  logic [STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;   // idle line is high
    else        sh_q <= sh_d;
  end

  assign q    = sh_q[STAGES-1];
  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/dws_timer.sv
module dws_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/dws_low_meter.sv
module dws_low_meter #(
  parameter int TW    = 8,
  parameter int LIMIT = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          level,
  output logic [TW-1:0] cnt,
  output logic          sat
);
  localparam logic [TW-1:0] LIM = TW'(LIMIT);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!en || level)     cnt_d = '0;
    else if (cnt_q != LIM) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
  assign sat = (cnt_q == LIM);
endmodule

// File: rtl/dwire_sensor_tx.sv
module dwire_sensor_tx
  import dws_pkg::*;
#(
  parameter int CLK_NS = 83,
  parameter int WORD_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_in,
  input  logic [WORD_W-1:0] word_in,
  output logic              pull_low,
  output logic              busy,
  output logic              done
);
  localparam int C_START = dur_cycles(500000, CLK_NS);
  localparam int C_WAIT  = dur_cycles(40000, CLK_NS);
  localparam int C_PRE   = dur_cycles(80000, CLK_NS);
  localparam int C_SLOT  = dur_cycles(50000, CLK_NS);
  localparam int C_ZERO  = dur_cycles(24000, CLK_NS);
  localparam int C_ONE   = dur_cycles(68000, CLK_NS);
  localparam int TW      = $clog2(C_START + 1);
  localparam int IW      = $clog2(WORD_W);

  localparam logic [TW-1:0] LD_WAIT = TW'(C_WAIT - 1);
  localparam logic [TW-1:0] LD_PRE  = TW'(C_PRE - 1);
  localparam logic [TW-1:0] LD_SLOT = TW'(C_SLOT - 1);
  localparam logic [TW-1:0] LD_ZERO = TW'(C_ZERO - 1);
  localparam logic [TW-1:0] LD_ONE  = TW'(C_ONE - 1);
  localparam logic [IW-1:0] IDX_TOP = IW'(WORD_W - 1);

  dws_state_e        st_q, st_d;
  logic [WORD_W-1:0] word_q;
  logic [IW-1:0]     idx_q, idx_d;
  logic              done_q, fin;
  logic              accept, tmr_ld, tmr_zero;
  logic [TW-1:0]     tmr_val;
  logic              bus_s, bus_rise, lo_sat;
  logic [TW-1:0]     lo_cnt;

  dws_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_in), .q(bus_s), .rise(bus_rise)
  );

  dws_low_meter #(.TW(TW), .LIMIT(C_START)) u_meter (
    .clk(clk), .rst_n(rst_n), .en(st_q == ST_IDLE), .level(bus_s),
    .cnt(lo_cnt), .sat(lo_sat)
  );

  dws_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_ld), .load_val(tmr_val),
    .zero(tmr_zero)
  );

  // next-state logic
  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    accept  = 1'b0;
    fin     = 1'b0;
    unique case (st_q)
      ST_IDLE: if (bus_rise && lo_sat) begin
        st_d = ST_GAP; tmr_ld = 1'b1; tmr_val = LD_WAIT;
        accept = 1'b1; idx_d = IDX_TOP;
      end
      ST_GAP: if (tmr_zero) begin
        st_d = ST_PRE_LO; tmr_ld = 1'b1; tmr_val = LD_PRE;
      end
      ST_PRE_LO: if (tmr_zero) begin
        st_d = ST_PRE_HI; tmr_ld = 1'b1; tmr_val = LD_PRE;
      end
      ST_PRE_HI: if (tmr_zero) begin
        st_d = ST_BIT_LO; tmr_ld = 1'b1; tmr_val = LD_SLOT;
      end
      ST_BIT_LO: if (tmr_zero) begin
        st_d = ST_BIT_HI; tmr_ld = 1'b1;
        tmr_val = word_q[idx_q] ? LD_ONE : LD_ZERO;
      end
      ST_BIT_HI: if (tmr_zero) begin
        tmr_ld = 1'b1; tmr_val = LD_SLOT;
        if (idx_q == '0) st_d = ST_TAIL_LO;
        else begin
          st_d  = ST_BIT_LO;
          idx_d = idx_q - 1'b1;
        end
      end
      ST_TAIL_LO: if (tmr_zero) begin
        st_d = ST_IDLE; fin = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      done_q <= fin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_q <= '0;
    else if (accept) word_q <= word_in;
  end

  assign pull_low = (st_q == ST_PRE_LO) || (st_q == ST_BIT_LO) ||
                    (st_q == ST_TAIL_LO);
  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;
endmodule

// File: rtl/dws_checker.sv
module dws_checker #(
  parameter int WORD_W    = 40,
  parameter int TW        = 8,
  parameter int START_CNT = 100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pull_low,
  input logic              busy,
  input logic              done,
  input logic [WORD_W-1:0] word_q,
  input logic [TW-1:0]     lo_cnt
);
  // R10: the line is pulled only inside a transaction
  p_pull_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pull_low |-> busy);

  // R10: done lasts one cycle
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: done coincides with the fall of busy
  p_done_at_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R2: a transaction opens only after a full-length host low
  p_start_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(lo_cnt) == TW'(START_CNT));

  // R9: captured word is frozen during the transaction
  p_word_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(word_q));
endmodule

bind dwire_sensor_tx dws_checker #(
  .WORD_W(WORD_W), .TW(TW), .START_CNT(C_START)
) i_dws_chk (
  .clk(clk), .rst_n(rst_n), .pull_low(pull_low), .busy(busy),
  .done(done), .word_q(word_q), .lo_cnt(lo_cnt)
);

// File: tb/test_dwire_sensor_tx.sv
module test_dwire_sensor_tx;
  localparam int TB_CLK_NS = 4000;   // timing generic scaled so frames stay short
  localparam int WORD_W    = 16;

  // R11: expected counts from the duration rule, computed here
  function automatic int cyc(input int ns);
    return ns / TB_CLK_NS + 1;
  endfunction

  localparam int E_START = 500000 / TB_CLK_NS + 1;
  localparam int E_WAIT  = 40000  / TB_CLK_NS + 1;
  localparam int E_PRE   = 80000  / TB_CLK_NS + 1;
  localparam int E_SLOT  = 50000  / TB_CLK_NS + 1;
  localparam int E_ZERO  = 24000  / TB_CLK_NS + 1;
  localparam int E_ONE   = 68000  / TB_CLK_NS + 1;

  logic clk = 1'b0;
  logic rst_n;
  logic host_low;
  logic [WORD_W-1:0] word_in;
  logic pull_low, busy, done;
  logic bus_in;

  int n_tests = 0;
  int n_fail  = 0;
  bit saw_busy, saw_pull;

  always #2 clk = ~clk;   // 250 MHz
  assign bus_in = ~(host_low | pull_low);

  dwire_sensor_tx #(.CLK_NS(TB_CLK_NS), .WORD_W(WORD_W)) i_dwire_sensor_tx (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .word_in(word_in),
    .pull_low(pull_low), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    if (busy)     saw_busy <= 1'b1;
    if (pull_low) saw_pull <= 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_run(input logic lvl, output int n);
    n = 0;
    while (pull_low == lvl && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic host_start(input int len);
    @(negedge clk);
    host_low = 1'b1;
    repeat (len) @(negedge clk);
    host_low = 1'b0;
  endtask

  task automatic rx_frame(input logic [WORD_W-1:0] exp_w);
    int n, lo, hi;
    logic [WORD_W-1:0] got;
    n = 0;
    while (1) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (pull_low || n > 2000) break;
    end
    chk(n == E_WAIT + 3, "R3 reply gap", n, E_WAIT + 3);
    chk(busy == 1'b1, "R10 busy in frame", int'(busy), 1);
    word_in = WORD_W'($urandom);   // R9: live input changes mid-frame
    count_run(1'b1, lo);
    chk(lo == E_PRE, "R4 preamble low", lo, E_PRE);
    count_run(1'b0, hi);
    chk(hi == E_PRE, "R4 preamble high", hi, E_PRE);
    got = '0;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      count_run(1'b1, lo);
      chk(lo == E_SLOT, "R5 bit low slot", lo, E_SLOT);
      count_run(1'b0, hi);
      chk(hi == (exp_w[i] ? E_ONE : E_ZERO), "R6 bit high length", hi,
          exp_w[i] ? E_ONE : E_ZERO);
      got = {got[WORD_W-2:0], (hi > (E_ZERO + E_ONE) / 2)};
    end
    chk(got == exp_w, "R7/R9 word msb first", int'(got), int'(exp_w));
    count_run(1'b1, lo);
    chk(lo == E_SLOT, "R8 trailing low", lo, E_SLOT);
    chk(done == 1'b1 && busy == 1'b0, "R10 done at release",
        {int'(done), int'(busy)}, 2);
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", int'(done), 0);
  endtask

  task automatic frame(input logic [WORD_W-1:0] w, input int len);
    word_in = w;
    host_start(len);
    rx_frame(w);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n = 1'b0; host_low = 1'b0; word_in = '0;
    saw_busy = 1'b0; saw_pull = 1'b0;
    chk(cyc(500000) == E_START, "R11 count rule", cyc(500000), E_START);
    repeat (3) @(negedge clk);
    chk(!pull_low && !busy && !done, "R1 in reset",
        {int'(pull_low), int'(busy), int'(done)}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pull_low && !busy && !done, "R1 after reset",
        {int'(pull_low), int'(busy), int'(done)}, 0);

    // R2: one cycle short of the threshold is ignored
    word_in = 16'hFFFF;
    host_start(E_START - 1);
    saw_busy = 1'b0; saw_pull = 1'b0;
    repeat (80) @(negedge clk);
    chk(!saw_busy, "R2 short low no busy", int'(saw_busy), 0);
    chk(!saw_pull, "R2 short low no pull", int'(saw_pull), 0);

    // R2: exactly the threshold is accepted; directed patterns
    frame(16'h0000, E_START);
    frame(16'hFFFF, E_START + 7);
    frame(16'hA5A5, E_START + 1);
    frame(16'h8000, E_START + 3);

    for (int k = 0; k < 6; k++)
      frame(WORD_W'($urandom), E_START + int'($urandom % 40));

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule